// File: doc/BRIEF.md
# Hybrid Strict-Priority / Weighted Round-Robin Queue Scheduler

This block picks, every clock cycle, which of the eight egress queues of one transmit channel is served next. A three-bit mode code splits the queues into two groups. The lowest-numbered queues form a strict-priority group. The rest share service by weight: each one gets a run of consecutive grants, and then the turn passes to the next queue round-robin. With the mode code, software chooses anywhere from zero to six strict queues, or all eight. A setting of exactly seven strict queues has no code.

Each queue holds a 16-bit weight. Software writes weights through a single command word, and the block raises a done flag one cycle after it accepts a write. Each channel/queue pair also has a disable bit, and a disabled queue is never served. Each cycle the block reads the per-queue non-empty flags and gives out at most one granted queue index. The channel the block serves is a parameter. The block takes its mode field and its disable bits from the shared configuration words at positions derived from that channel number.

Top module: `hyb_sched_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grantValid` and `cmdDone` are low when no queue is non-empty.
- R2: The mode field is `modeWord[4*(CHAN_ID%8)+2 : 4*(CHAN_ID%8)]`. Code 0 puts all queues in the weighted group. Code 1 makes all queues strict. A code m in 2..7 makes queues 0..m-2 strict (m-1 queues) and puts the rest in the weighted group.
- R3: When any strict queue is eligible, the grant is the lowest-indexed eligible strict queue. Such a grant leaves the weighted group's turn and run count unchanged.
- R4: The weighted queue that holds the turn is granted again while it is eligible and has received fewer consecutive grants than its weight. Otherwise the grant goes to the next eligible weighted queue in increasing circular index order, and that grant counts as the first of its run.
- R5: A stored weight of 0 behaves exactly like a weight of 1.
- R6: A command with bit 31 set is a weight write, with channel in [23:19], queue in [18:16] and weight in [15:0]. The weight is stored when the channel equals `CHAN_ID`, and it governs grants from the next cycle on.
- R7: `cmdDone` is high in exactly the cycle after a weight write is presented. A command with bit 31 clear raises no done and changes no weight.
- R8: A weight write for a different channel leaves all weights unchanged but still raises `cmdDone`.
- R9: Bit `q + 8*(CHAN_ID%4)` of `disableWord` disables queue q. A disabled queue is never granted, whatever its group.
- R10: When no queue is both non-empty and enabled, `grantValid` is low and `grantIdx` is 0.
- R11: After reset all weights are 0, and the first weighted grant goes to the lowest-indexed eligible weighted queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWord | input | 32 | Shared mode register; this channel's 3-bit field is selected by CHAN_ID |
| disableWord | input | 32 | Shared queue-disable register; this channel's 8 bits are selected by CHAN_ID |
| cmdValid | input | 1 | Command word is presented this cycle |
| cmdWord | input | 32 | Weight command: write bit, channel, queue, weight |
| cmdDone | output | 1 | Pulses the cycle after a weight write is accepted |
| qNotEmpty | input | 8 | Per-queue non-empty flags |
| grantValid | output | 1 | A queue is granted this cycle |
| grantIdx | output | 3 | Index of the granted queue |

## Verification
Some properties are checked by assertions on every cycle. A grant must always name a non-empty, enabled queue. With nothing eligible, no grant may appear. An eligible strict queue must always win over the weighted group. `cmdDone` must follow exactly one cycle after each write and at no other time. Other behaviour depends on history, and only the bench scenarios can show it. This covers how long each weighted run lasts, where the round-robin turn moves next, a zero weight acting as one, writes for another channel having no effect, and the way the mode field and disable bits are located inside the shared words. The bench checks these against a reference model, cycle by cycle.

// File: rtl/hyb_sched_pkg.sv
`timescale 1ns/1ps
package hyb_sched_pkg;
  localparam int QUEUE_NUM = 8;
  localparam int WEIGHT_W  = 16;
  localparam int IDX_W     = $clog2(QUEUE_NUM);
  localparam int CNT_W     = IDX_W + 1;
  localparam int WORD_W    = 32;
  localparam int MODE_W    = 3;
  localparam int WR_BIT    = 31;
  localparam int CHAN_LSB  = 19;
  localparam int CHAN_W    = 5;
  localparam int QSEL_LSB  = 16;

  typedef struct packed {
    logic                 weightWe;
    logic [IDX_W-1:0]     weightQ;
    logic [WEIGHT_W-1:0]  weightVal;
    logic [CNT_W-1:0]     strictCount;
    logic [QUEUE_NUM-1:0] disMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/hyb_sched_ctrl.sv
`timescale 1ns/1ps
module hyb_sched_ctrl
  import hyb_sched_pkg::*;
#(
  parameter int CHAN_ID = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] modeWord,
  input  logic [WORD_W-1:0] disableWord,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  output ctrlStrobe_t       strobe,
  output logic              cmdDone
);
  localparam int MODE_LSB = 4 * (CHAN_ID % 8);
  localparam int DIS_LSB  = QUEUE_NUM * (CHAN_ID % 4);
  localparam logic [CHAN_W-1:0] CHAN_SEL = CHAN_W'(CHAN_ID);

  logic              isWrite;
  logic              chanHit;
  logic [MODE_W-1:0] modeField;

  always_comb begin
    isWrite   = cmdValid && cmdWord[WR_BIT];
    chanHit   = (cmdWord[CHAN_LSB +: CHAN_W] == CHAN_SEL);
    modeField = modeWord[MODE_LSB +: MODE_W];

    strobe.weightWe  = isWrite && chanHit;
    strobe.weightQ   = cmdWord[QSEL_LSB +: IDX_W];
    strobe.weightVal = cmdWord[WEIGHT_W-1:0];
    strobe.disMask   = disableWord[DIS_LSB +: QUEUE_NUM];

    case (modeField)
      3'd0:    strobe.strictCount = '0;
      3'd1:    strobe.strictCount = CNT_W'(QUEUE_NUM);
      default: strobe.strictCount = CNT_W'(modeField) - CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdDone <= 1'b0;
    else       cmdDone <= isWrite;
  end

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWord[WR_BIT]) |=> cmdDone); // R7
  AST_DONE_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdWord[WR_BIT]) |=> !cmdDone); // R7
  AST_STRICT_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.strictCount <= CNT_W'(QUEUE_NUM)) && (strobe.strictCount != CNT_W'(QUEUE_NUM-1))); // R2
endmodule

// File: rtl/hyb_sched_dp.sv
`timescale 1ns/1ps
module hyb_sched_dp
  import hyb_sched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [QUEUE_NUM-1:0] qNotEmpty,
  output logic                 grantValid,
  output logic [IDX_W-1:0]     grantIdx
);
  logic [WEIGHT_W-1:0]  weightMem [QUEUE_NUM];
  logic [IDX_W-1:0]     curQ;
  logic [WEIGHT_W-1:0]  usedCnt;

  logic [QUEUE_NUM-1:0] eligMask, strictMask, strictElig, wrrElig;
  logic [IDX_W-1:0]     strictIdx, rrIdx;
  logic                 strictHit, wrrHit, stay;
  logic [WEIGHT_W-1:0]  curWeff;

  always_comb begin
    eligMask = qNotEmpty & ~strobe.disMask;
    for (int q = 0; q < QUEUE_NUM; q++)
      strictMask[q] = (CNT_W'(q) < strobe.strictCount);
    strictElig = eligMask & strictMask;
    wrrElig    = eligMask & ~strictMask;
    strictHit  = |strictElig;
    wrrHit     = |wrrElig;
  end

  // lowest eligible strict queue
  always_comb begin
    logic found;
    found     = 1'b0;
    strictIdx = '0;
    for (int q = 0; q < QUEUE_NUM; q++) begin
      if (strictElig[q] && !found) begin
        strictIdx = IDX_W'(q);
        found     = 1'b1;
      end
    end
  end

  // next eligible weighted queue after the turn holder, circularly
  always_comb begin
    logic             found;
    logic [IDX_W-1:0] cand;
    found = 1'b0;
    rrIdx = curQ;
    for (int off = 1; off <= QUEUE_NUM; off++) begin
      cand = IDX_W'((int'(curQ) + off) % QUEUE_NUM);
      if (wrrElig[cand] && !found) begin
        rrIdx = cand;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    curWeff = (weightMem[curQ] == '0) ? WEIGHT_W'(1) : weightMem[curQ];
    stay    = wrrElig[curQ] && (usedCnt < curWeff);
    if (strictHit) begin
      grantValid = 1'b1;
      grantIdx   = strictIdx;
    end else if (wrrHit) begin
      grantValid = 1'b1;
      grantIdx   = stay ? curQ : rrIdx;
    end else begin
      grantValid = 1'b0;
      grantIdx   = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < QUEUE_NUM; q++) weightMem[q] <= '0;
    end else if (strobe.weightWe) begin
      weightMem[strobe.weightQ] <= strobe.weightVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ    <= IDX_W'(QUEUE_NUM - 1);
      usedCnt <= '1;
    end else if (!strictHit && wrrHit) begin
      if (stay) begin
        usedCnt <= usedCnt + WEIGHT_W'(1);
      end else begin
        curQ    <= rrIdx;
        usedCnt <= WEIGHT_W'(1);
      end
    end
  end

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (qNotEmpty[grantIdx] && !strobe.disMask[grantIdx])); // R9
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    ((qNotEmpty & ~strobe.disMask) == '0) |-> (!grantValid && grantIdx == '0)); // R10
  AST_STRICT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ((qNotEmpty & ~strobe.disMask & strictMask) != '0) |-> (grantValid && strictMask[grantIdx])); // R3
  AST_STRICT_HOLDS_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && strictMask[grantIdx]) |=> ($stable(curQ) && $stable(usedCnt))); // R3
endmodule

// File: rtl/hyb_sched_top.sv
`timescale 1ns/1ps
module hyb_sched_top
  import hyb_sched_pkg::*;
#(
  parameter int CHAN_ID = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] modeWord,
  input  logic [31:0] disableWord,
  input  logic        cmdValid,
  input  logic [31:0] cmdWord,
  output logic        cmdDone,
  input  logic [7:0]  qNotEmpty,
  output logic        grantValid,
  output logic [2:0]  grantIdx
);
  ctrlStrobe_t strobe;

  hyb_sched_ctrl #(.CHAN_ID(CHAN_ID)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeWord    (modeWord),
    .disableWord (disableWord),
    .cmdValid    (cmdValid),
    .cmdWord     (cmdWord),
    .strobe      (strobe),
    .cmdDone     (cmdDone)
  );

  hyb_sched_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .qNotEmpty  (qNotEmpty),
    .grantValid (grantValid),
    .grantIdx   (grantIdx)
  );
endmodule

// File: tb/sim_hyb_sched_top.sv
`timescale 1ns/1ps
module sim_hyb_sched_top;
  localparam int CH      = 5;
  localparam int MODE_LO = 4 * (CH % 8);
  localparam int DIS_LO  = 8 * (CH % 4);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] modeWord = '0;
  logic [31:0] disableWord = '0;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdWord = '0;
  logic        cmdDone;
  logic [7:0]  qNotEmpty = '0;
  logic        grantValid;
  logic [2:0]  grantIdx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  int  mW [8];
  int  mCur;
  int  mUsed;
  bit  expDone;

  always #4 clk = ~clk;

  hyb_sched_top #(.CHAN_ID(CH)) u0 (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .disableWord(disableWord),
    .cmdValid(cmdValid), .cmdWord(cmdWord), .cmdDone(cmdDone),
    .qNotEmpty(qNotEmpty), .grantValid(grantValid), .grantIdx(grantIdx)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int strict_of(input int mode);
    if (mode == 0) return 0;
    if (mode == 1) return 8;
    return mode - 1;
  endfunction

  function automatic int weff(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic logic [31:0] mk_cmd(input bit wr, input int chan, input int q, input int w);
    return {wr, 1'b0, 6'd0, 5'(chan), 3'(q), 16'(w)};
  endfunction

  function automatic void model_reset();
    for (int q = 0; q < 8; q++) mW[q] = 0;
    mCur = 7; mUsed = 65535; expDone = 0;
  endfunction

  task automatic step(input logic [7:0] ne, input logic [7:0] dis, input int mode,
                      input bit cv, input logic [31:0] cw, input string tag);
    int sc, idx, nxt;
    bit v, isStrict, stayHere;
    logic [7:0] elig;
    @(negedge clk);
    qNotEmpty   = ne;
    modeWord    = 32'h7777_7777;
    modeWord[MODE_LO +: 3] = 3'(mode);
    disableWord = 32'hA5A5_A5A5;
    disableWord[DIS_LO +: 8] = dis;
    cmdValid    = cv;
    cmdWord     = cw;
    #2;
    sc   = strict_of(mode);
    elig = ne & ~dis;
    v = 0; idx = 0; isStrict = 0; stayHere = 0; nxt = mCur;
    for (int q = 0; q < 8; q++)
      if (!v && q < sc && elig[q]) begin v = 1; idx = q; isStrict = 1; end
    if (!v) begin
      if (mCur >= sc && elig[mCur] && mUsed < weff(mW[mCur])) begin
        v = 1; idx = mCur; stayHere = 1;
      end else begin
        for (int off = 1; off <= 8; off++) begin
          nxt = (mCur + off) % 8;
          if (!v && nxt >= sc && elig[nxt]) begin v = 1; idx = nxt; end
        end
      end
    end
    check(grantValid === v, tag, "grantValid", int'(grantValid), int'(v));
    check(grantIdx === 3'(idx), tag, "grantIdx", int'(grantIdx), idx);
    check(cmdDone === expDone, "R7", "cmdDone", int'(cmdDone), int'(expDone));
    if (v && !isStrict) begin
      if (stayHere) mUsed++;
      else begin mCur = idx; mUsed = 1; end
    end
    if (cv && cw[31] && cw[23:19] == 5'(CH)) mW[cw[18:16]] = int'(cw[15:0]);
    expDone = cv && cw[31];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #2;
    check(grantValid === 1'b0, "R1", "grantValid in reset", int'(grantValid), 0);
    check(cmdDone === 1'b0, "R1", "cmdDone in reset", int'(cmdDone), 0);
    @(negedge clk);
    rstN = 1'b1;
    step(8'h00, 8'h00, 0, 0, '0, "R1");

    // all weighted, default weights act as 1: 0..7 in order
    for (int i = 0; i < 8; i++) step(8'hFF, 8'h00, 0, 0, '0, "R11");

    // weight writes, done pulse
    step(8'h00, 8'h00, 0, 1, mk_cmd(1, CH, 0, 3), "R6");
    step(8'h00, 8'h00, 0, 1, mk_cmd(1, CH, 2, 2), "R6");
    step(8'h00, 8'h00, 0, 1, mk_cmd(1, CH, 1, 0), "R5");
    for (int i = 0; i < 16; i++) step(8'h07, 8'h00, 0, 0, '0, "R4");

    // other channel write ignored but done; read command no effect
    step(8'h00, 8'h00, 0, 1, mk_cmd(1, CH + 1, 0, 6), "R8");
    step(8'h00, 8'h00, 0, 1, mk_cmd(0, CH, 0, 9), "R7");
    for (int i = 0; i < 12; i++) step(8'h03, 8'h00, 0, 0, '0, "R8");

    // all strict, then 3 strict + weighted
    step(8'hF0, 8'h00, 1, 0, '0, "R2");
    step(8'hF6, 8'h00, 1, 0, '0, "R3");
    step(8'h80, 8'h00, 1, 0, '0, "R2");
    for (int i = 0; i < 10; i++) step(8'hFC, 8'h00, 4, 0, '0, "R2");
    step(8'hFF, 8'h00, 4, 0, '0, "R3");
    step(8'hF8, 8'h00, 4, 0, '0, "R3");

    // disables
    step(8'hFF, 8'hFF, 1, 0, '0, "R9");
    step(8'hFF, 8'h7F, 1, 0, '0, "R9");
    for (int i = 0; i < 6; i++) step(8'hFF, 8'h0F, 0, 0, '0, "R9");
    step(8'h00, 8'h00, 7, 0, '0, "R10");
    step(8'h0F, 8'h0F, 3, 0, '0, "R10");

    // seeded random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ne, dis;
      int mode, chan;
      bit cv;
      ne   = 8'($urandom);
      if (($urandom % 4) == 0) ne = 8'($urandom) & 8'($urandom);
      dis  = (($urandom % 3) == 0) ? (8'($urandom) & 8'($urandom)) : 8'h00;
      mode = (i / 200) % 8;
      cv   = (($urandom % 6) == 0);
      chan = (($urandom % 2) == 0) ? CH : int'($urandom % 32);
      step(ne, dis, mode, cv,
           mk_cmd(($urandom % 4) != 0, chan, int'($urandom % 8), int'($urandom % 6)), "R4");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule